// File: doc/BRIEF.md
# Wide Atomic Store Sequencer

This block takes one 32-bit instruction word for a 64-byte single-copy atomic store and carries it out. It first checks the fixed opcode bits, the feature-enable input and the legality of the first data register number. It then reads eight consecutive 64-bit general registers through a single register-file read port, one per cycle, and assembles them into a 512-bit beat. When the access is big-endian, each doubleword is byte-reversed on its own. The base address comes either from a general register or from the stack pointer. After the alignment checks, the block issues a single 512-bit store request on a valid/ready interface.

Faults cancel the store. A fault is reported as a one-cycle pulse with a cause code. The store returns no status, so nothing is written back to the register file. The memory system, tag checking and the choice of which locations accept the access are handled elsewhere. The block only carries a tag-checked flag with the request.

Top module: `wide_store_seq`

## Requirements
- R1: An instruction is accepted only while the block is idle (`instr_ready` high). `busy` rises on the cycle after acceptance and stays high until the store handshake completes or a fault is reported. An instruction offered while busy is ignored.
- R2: If bits [31:10] of the word differ from 1111100000111111100100, or if `feat_en` was low at acceptance, the block reports a fault with cause 0 one cycle after acceptance. No store is issued.
- R3: If the first data register number (bits [4:0]) has bits [4:3] equal to 11, or has bit 0 set, the block reports a fault with cause 0 one cycle after acceptance.
- R4: The base register number is bits [9:5]. On the cycle after acceptance, the read port addresses that register. On the next eight cycles it addresses the first data register plus 0 through 7, one per cycle. The resulting store request or check fault appears ten cycles after acceptance.
- R5: Doubleword i of the stored beat (bits [64i+63:64i]) holds register (first data register + i), so the first register fills the least significant doubleword.
- R6: When `big_endian` was high at acceptance, each doubleword is byte-reversed individually. The order of the doublewords is unchanged.
- R7: When the base register number is 31, the base address is `sp`. If `sp[3:0]` is nonzero, the block reports a fault with cause 1 and no store.
- R8: A base address with nonzero bits [5:0] gives a fault with cause 2 and no store. A stack-pointer fault (cause 1) takes priority. Every issued request has address bits [5:0] equal to zero.
- R9: `st_tagchk` is high when the base register number is not 31 and low when it is 31.
- R10: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_addr`, `st_data` and `st_tagchk` hold their values.
- R11: A fault pulse lasts exactly one cycle, never coincides with `st_valid`, and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Feature enable, sampled at acceptance |
| big_endian | input | 1 | Big-endian access, sampled at acceptance |
| instr_valid | input | 1 | Instruction word offered |
| instr | input | 32 | Instruction word |
| instr_ready | output | 1 | Block idle, word accepted when valid |
| busy | output | 1 | Instruction in progress |
| sp | input | 64 | Stack pointer value |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | 64 | Register-file read data, same cycle |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store request accepted |
| st_addr | output | 64 | Store address |
| st_data | output | 512 | Store data beat |
| st_tagchk | output | 1 | Tag-checked flag |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_cause | output | 2 | 0 undefined, 1 stack-pointer alignment, 2 data alignment |

## Verification
If the read counter slipped or the state machine skipped a step, the wrong or shifted doublewords would show up in `st_data`. The request would also appear earlier or later than ten cycles after acceptance, so the error is visible within the same instruction. If the fault decision were stuck or wrong, the bench would see a request where a fault pulse was expected, or the reverse, or a wrong cause code. A lost hold during backpressure would change the request fields on the next cycle. Latched mode inputs are checked by changing them, and by offering a second word, while the first instruction is still in flight.

// File: rtl/wide_store_seq.sv
module wide_store_seq #(
  parameter int DW   = 64,
  parameter int NREG = 8,
  parameter int RW   = 5,
  parameter int SPA  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 feat_en,
  input  logic                 big_endian,
  input  logic                 instr_valid,
  input  logic [31:0]          instr,
  output logic                 instr_ready,
  output logic                 busy,
  input  logic [DW-1:0]        sp,
  output logic [RW-1:0]        rf_raddr,
  input  logic [DW-1:0]        rf_rdata,
  output logic                 st_valid,
  input  logic                 st_ready,
  output logic [DW-1:0]        st_addr,
  output logic [DW*NREG-1:0]   st_data,
  output logic                 st_tagchk,
  output logic                 fault_valid,
  output logic [1:0]           fault_cause
);
  localparam int BEAT = DW * NREG;
  localparam int CW   = $clog2(NREG);
  localparam int NB   = DW / 8;
  localparam int ALN  = $clog2(BEAT / 8);
  localparam int OPW  = 32 - 2 * RW;
  localparam logic [OPW-1:0] OPC   = OPW'(22'b1111100000111111100100);
  localparam logic [RW-1:0]  SPNUM = '1;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_READ, S_CHK, S_ISS} state_t;

  state_t          state;
  logic [31:0]     insn_q;
  logic            fe_q, be_q;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   base_q;
  logic [BEAT-1:0] beat_q;
  logic            rd_act;

  wire [RW-1:0] rn = insn_q[2*RW-1:RW];
  wire [RW-1:0] rt = insn_q[RW-1:0];
  wire use_sp = (rn == SPNUM);
  wire undef  = (insn_q[31:2*RW] != OPC) || !fe_q ||
                (rt[RW-1:RW-2] == 2'b11) || rt[0];

  function automatic logic [DW-1:0] bswap(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[8*b +: 8] = v[DW-8-8*b +: 8];
    return r;
  endfunction

  assign instr_ready = (state == S_IDLE);
  assign busy        = (state != S_IDLE);
  assign rd_act      = (state == S_READ);
  assign rf_raddr    = rd_act ? rt + RW'(cnt) : rn;
  assign st_addr     = base_q;
  assign st_data     = beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      insn_q      <= '0;
      fe_q        <= 1'b0;
      be_q        <= 1'b0;
      cnt         <= '0;
      base_q      <= '0;
      beat_q      <= '0;
      st_valid    <= 1'b0;
      st_tagchk   <= 1'b0;
      fault_valid <= 1'b0;
      fault_cause <= 2'd0;
    end else begin
      fault_valid <= 1'b0;
      case (state)
        S_IDLE: if (instr_valid) begin
          insn_q <= instr;
          fe_q   <= feat_en;
          be_q   <= big_endian;
          state  <= S_DEC;
        end
        S_DEC: if (undef) begin
          fault_valid <= 1'b1;
          fault_cause <= 2'd0;
          state       <= S_IDLE;
        end else begin
          base_q <= use_sp ? sp : rf_rdata;
          cnt    <= '0;
          state  <= S_READ;
        end
        S_READ: begin
          beat_q[cnt*DW +: DW] <= be_q ? bswap(rf_rdata) : rf_rdata;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(NREG - 1)) state <= S_CHK;
        end
        S_CHK: if (use_sp && base_q[SPA-1:0] != '0) begin
          fault_valid <= 1'b1;
          fault_cause <= 2'd1;
          state       <= S_IDLE;
        end else if (base_q[ALN-1:0] != '0) begin
          fault_valid <= 1'b1;
          fault_cause <= 2'd2;
          state       <= S_IDLE;
        end else begin
          st_valid  <= 1'b1;
          st_tagchk <= !use_sp;
          state     <= S_ISS;
        end
        S_ISS: if (st_ready) begin
          st_valid <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wide_store_seq_chk.sv
module wide_store_seq_chk #(
  parameter int DW   = 64,
  parameter int NREG = 8,
  parameter int RW   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               instr_valid,
  input logic               instr_ready,
  input logic               busy,
  input logic [RW-1:0]      rf_raddr,
  input logic               rd_act,
  input logic               st_valid,
  input logic               st_ready,
  input logic [DW-1:0]      st_addr,
  input logic [DW*NREG-1:0] st_data,
  input logic               st_tagchk,
  input logic               fault_valid
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_ready |=> busy); // R1

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act && $past(rd_act) |-> rf_raddr == $past(rf_raddr) + 1'b1); // R4

  AST_ST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> st_addr[5:0] == 6'd0); // R8

  AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_addr) &&
      $stable(st_data) && $stable(st_tagchk)); // R10

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid); // R11

  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !st_valid && !busy); // R11
endmodule

bind wide_store_seq wide_store_seq_chk #(.DW(DW), .NREG(NREG), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
  .busy(busy), .rf_raddr(rf_raddr), .rd_act(rd_act), .st_valid(st_valid),
  .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
  .st_tagchk(st_tagchk), .fault_valid(fault_valid)
);

// File: tb/tb_wide_store_seq.sv
`timescale 1ns/1ps
module tb_wide_store_seq;
  localparam logic [31:0] BASEOP = 32'hF83F9000;

  logic clk = 0, rst_n = 0;
  logic feat_en = 1, big_endian = 0, instr_valid = 0, st_ready = 0;
  logic [31:0] instr = 0;
  logic [63:0] sp = 0;
  logic instr_ready, busy, st_valid, st_tagchk, fault_valid;
  logic [4:0] rf_raddr;
  logic [63:0] rf_rdata, st_addr;
  logic [511:0] st_data;
  logic [1:0] fault_cause;
  logic [63:0] regs [32];

  int tests = 0, fails = 0;

  always #4 clk = ~clk;
  assign rf_rdata = regs[rf_raddr];

  wide_store_seq dut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .big_endian(big_endian),
    .instr_valid(instr_valid), .instr(instr), .instr_ready(instr_ready),
    .busy(busy), .sp(sp), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_tagchk(st_tagchk), .fault_valid(fault_valid),
    .fault_cause(fault_cause));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] swap64(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[56-8*b +: 8];
    return r;
  endfunction

  function automatic logic [511:0] exp_beat(input logic [4:0] rt, input bit be);
    logic [511:0] d;
    for (int i = 0; i < 8; i++) d[64*i +: 64] = be ? swap64(regs[rt+i]) : regs[rt+i];
    return d;
  endfunction

  task automatic run_case(input logic [31:0] ins, input bit fe, input bit be,
                          input int hold, input bit poke);
    logic [4:0] rt, rn;
    logic [63:0] ea;
    logic [511:0] ed;
    bit bad_op, bad_rt, fault;
    int cause, lat, k;
    string rq;
    rt = ins[4:0]; rn = ins[9:5];
    bad_op = (ins[31:10] != BASEOP[31:10]) || !fe;
    bad_rt = (rt[4:3] == 2'b11) || rt[0];
    ea = (rn == 5'd31) ? sp : regs[rn];
    ed = (bad_op || bad_rt) ? '0 : exp_beat(rt, be);
    fault = 1; lat = 10;
    if (bad_op || bad_rt) begin cause = 0; lat = 1; rq = bad_rt ? "R3" : "R2"; end
    else if (rn == 5'd31 && sp[3:0] != 0) begin cause = 1; rq = "R7"; end
    else if (ea[5:0] != 0) begin cause = 2; rq = "R8"; end
    else begin fault = 0; cause = 0; rq = be ? "R6" : "R5"; end

    @(negedge clk);
    check(instr_ready === 1'b1, "R1", "ready in idle", 512'(instr_ready), 1);
    instr_valid = 1; instr = ins; feat_en = fe; big_endian = be;
    @(negedge clk);
    instr_valid = 0;
    check(busy === 1'b1, "R1", "busy after accept", 512'(busy), 1);
    k = 0;
    while (k < 20 && !(st_valid || fault_valid)) begin
      @(negedge clk); k++;
      if (poke && k == 3) begin
        check(instr_ready === 1'b0, "R1", "ready while busy", 512'(instr_ready), 0);
        instr_valid = 1; instr = BASEOP | 32'd2; big_endian = !be; feat_en = !fe;
      end
      if (poke && k == 4) instr_valid = 0;
    end
    instr_valid = 0;
    check(k == lat, "R4", "result latency", 512'(k), 512'(lat));
    if (fault) begin
      check(fault_valid === 1'b1 && fault_cause == 2'(cause), rq, "fault cause",
            512'({fault_valid, fault_cause}), 512'({1'b1, 2'(cause)}));
      check(st_valid === 1'b0, "R11", "no store with fault", 512'(st_valid), 0);
      @(negedge clk);
      check(fault_valid === 1'b0 && busy === 1'b0, "R11", "pulse ends idle",
            512'({fault_valid, busy}), 0);
    end else begin
      check(st_valid === 1'b1, rq, "store issued", 512'(st_valid), 1);
      check(st_addr === ea, (rn == 5'd31) ? "R7" : "R4", "store address",
            512'(st_addr), 512'(ea));
      check(st_data === ed, rq, "store data", st_data, ed);
      check(st_tagchk === (rn != 5'd31), "R9", "tag flag", 512'(st_tagchk),
            512'(rn != 5'd31));
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        check(st_valid === 1'b1 && st_addr === ea && st_data === ed &&
              st_tagchk === (rn != 5'd31), "R10", "hold under backpressure",
              st_data, ed);
      end
      st_ready = 1;
      @(negedge clk);
      st_ready = 0;
      check(st_valid === 1'b0 && busy === 1'b0, "R1", "idle after handshake",
            512'({st_valid, busy}), 0);
    end
    if (poke) begin
      for (int w = 0; w < 14; w++) begin
        @(negedge clk);
        check(!st_valid && !fault_valid && !busy, "R1", "ignored word had no effect",
              512'({st_valid, fault_valid, busy}), 0);
      end
    end
  endtask

  task automatic fill_regs();
    for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R1 watchdog expired: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    fill_regs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !st_valid && !fault_valid && instr_ready, "R1", "reset state",
          512'({busy, st_valid, fault_valid, instr_ready}), 1);

    regs[1][5:0] = 0;
    run_case(BASEOP | (5'd1 << 5) | 5'd0, 1, 0, 0, 0);        // R5 little-endian
    regs[3][5:0] = 0;
    run_case(BASEOP | (5'd3 << 5) | 5'd22, 1, 1, 2, 0);       // R6 big-endian, top legal Rt
    sp = 64'h0000_1234_5678_9A40;
    run_case(BASEOP | (5'd31 << 5) | 5'd8, 1, 0, 0, 0);       // R7 SP base, R9 tag low
    sp = 64'h0000_0000_0000_1008;
    run_case(BASEOP | (5'd31 << 5) | 5'd8, 1, 0, 0, 0);       // R7 cause 1
    sp = 64'h0000_0000_0000_1010;
    run_case(BASEOP | (5'd31 << 5) | 5'd8, 1, 0, 0, 0);       // R8 cause 2 via SP
    regs[5] = 64'h0000_0000_0000_2020;
    run_case(BASEOP | (5'd5 << 5) | 5'd4, 1, 0, 0, 0);        // R8 misaligned register base
    run_case(BASEOP | (5'd2 << 5) | 5'd1, 1, 0, 0, 0);        // R3 odd Rt
    run_case(BASEOP | (5'd2 << 5) | 5'd24, 1, 0, 0, 0);       // R3 Rt[4:3]=11
    regs[2][5:0] = 0;
    run_case(BASEOP | (5'd2 << 5) | 5'd4, 0, 0, 0, 0);        // R2 feature off
    run_case((BASEOP ^ 32'h0000_0400) | (5'd2 << 5), 1, 0, 0, 0); // R2 opcode bit
    regs[7][5:0] = 0;
    run_case(BASEOP | (5'd7 << 5) | 5'd10, 1, 0, 5, 0);       // R10 long backpressure
    regs[9][5:0] = 0;
    run_case(BASEOP | (5'd9 << 5) | 5'd12, 1, 1, 1, 1);       // R1 word while busy ignored

    for (int n = 0; n < 60; n++) begin
      logic [31:0] w;
      logic [4:0] rn, rt;
      fill_regs();
      rn = 5'($urandom); rt = 5'($urandom);
      if ($urandom % 3 != 0) rt = {rt[4] & ~rt[3], rt[3], rt[2:1], 1'b0};
      w = BASEOP | (32'(rn) << 5) | 32'(rt);
      if ($urandom % 8 == 0) w = w ^ (32'h400 << ($urandom % 22));
      if ($urandom % 4 != 0) regs[rn][5:0] = 0;
      sp = {$urandom, $urandom};
      case ($urandom % 3)
        0: sp[5:0] = 0;
        1: sp[3:0] = 0;
        default: ;
      endcase
      run_case(w, ($urandom % 10) != 0, $urandom % 2, $urandom % 4, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule